// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a processor's watchdog line for signs of life. Any change of level on that line, rising or falling, counts as a kick. If no kick arrives within a programmable number of clock cycles, the active-low watchdog output drops and stays down. It stays down until the timer is cleared again, either by a kick or by one of the other clear conditions.

Three other conditions hold the timer cleared: the supervisory reset being asserted, a flag saying the watchdog line is floating, and a low supply. A floating line therefore turns the watchdog off. While the supply is below threshold the output is forced low combinationally. It comes back high in the same cycle the supply recovers, with no minimum low time. A timeout does not reset anything by itself. The system only sees a reset if the output is wired externally to a manual-reset input.

The timeout length is given in clock cycles. By default it is derived from a clock frequency and a timeout in milliseconds, and the timeout should fall between 1.00 s and 2.25 s. The watchdog line and the floating flag each pass through a two-stage synchroniser before they are used.

Top module: `wdt_edge_watchdog`

## Requirements
- R1: While `rst_n` is low, the timer is cleared and `wdo_n` follows `supply_ok` (high when the supply is good).
- R2: When no clear condition occurs, `wdo_n` falls exactly TIMEOUT_CYCLES clock cycles after the last rising clock edge that sampled a clear condition. Reset release counts as such an edge.
- R3: A rising or a falling change of `wdi` clears the timer. The clear takes effect at the third rising clock edge after the change: two synchroniser stages, then the comparison of consecutive samples.
- R4: While `rst_asserted` is high, the timer is held cleared, whatever the duration.
- R5: While `wdi_float` is high, the timer is held cleared and `wdo_n` stays high indefinitely. The flag is synchronised like `wdi`, so it takes effect at the third rising edge after it rises, and its last clearing edge is the second edge after it falls.
- R6: Once `wdo_n` has fallen on a timeout, it stays low until a clear condition is sampled.
- R7: A `wdi` high pulse lasting a single clock period is seen as activity. Its two changes clear the timer at the third and fourth rising edges after it starts.
- R8: When `supply_ok` is low, `wdo_n` is low in the same cycle, and the timer is held cleared.
- R9: When `supply_ok` returns high, `wdo_n` goes high in the same cycle, with no minimum low time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| wdi | input | 1 | Watchdog kick line from the processor, asynchronous |
| wdi_float | input | 1 | High when the kick line is sensed as floating, asynchronous |
| supply_ok | input | 1 | High when the supply is above the reset threshold, synchronous to clk |
| rst_asserted | input | 1 | High while the supervisory reset output is asserted, synchronous to clk |
| wdo_n | output | 1 | Active-low watchdog output |

## Verification
The properties assume that `supply_ok` and `rst_asserted` come from logic clocked by `clk`, so they change only between edges. They also assume that `wdi` and `wdi_float` reach the timer only through their synchronisers. The stimulus changes every input on the falling clock edge, which honours both assumptions. It holds each `wdi` level for at least one full period, so every change is sampled. Expected switching cycles are counted from the input change through each register stage.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Sources that hold the watchdog timer cleared.
  typedef struct packed {
    logic kick;        // synchronised edge on the kick line
    logic floating;    // synchronised floating indication
    logic sys_reset;   // supervisory reset asserted
    logic low_supply;  // supply below threshold
  } wdt_clear_t;

  function automatic logic wdt_any_clear(input wdt_clear_t c);
    return c.kick | c.floating | c.sys_reset | c.low_supply;
  endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = async_in;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/wdt_edge_det.sv
module wdt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic edge_out
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = level_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign edge_out = level_in ^ prev_q;

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned TIMEOUT_CYCLES = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic expired
);

  localparam int unsigned CNT_W = (TIMEOUT_CYCLES < 2) ? 1 : $clog2(TIMEOUT_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;
  logic             cnt_en;

  assign cnt_en = !exp_q;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (clear) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == LAST) exp_d = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired = exp_q;

endmodule

// File: rtl/wdt_edge_watchdog.sv
module wdt_edge_watchdog #(
  parameter int unsigned CLK_FREQ_HZ    = 1_000_000,
  parameter int unsigned TIMEOUT_MS     = 1600,
  parameter int unsigned TIMEOUT_CYCLES = (CLK_FREQ_HZ / 1000) * TIMEOUT_MS,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi,
  input  logic wdi_float,
  input  logic supply_ok,
  input  logic rst_asserted,
  output logic wdo_n
);

  import wdt_pkg::*;

  logic [1:0] raw_in, sync_in;
  logic       kick_lvl;
  logic       float_s;
  logic       edge_evt;
  logic       clear_evt;
  logic       timed_out;
  wdt_clear_t clr;

  assign raw_in = {wdi_float, wdi};

  wdt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (raw_in),
    .sync_out (sync_in)
  );

  assign kick_lvl = sync_in[0];
  assign float_s  = sync_in[1];

  wdt_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (kick_lvl),
    .edge_out (edge_evt)
  );

  always_comb begin
    clr.kick       = edge_evt;
    clr.floating   = float_s;
    clr.sys_reset  = rst_asserted;
    clr.low_supply = !supply_ok;
    clear_evt      = wdt_any_clear(clr);
  end

  wdt_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_evt),
    .expired (timed_out)
  );

  assign wdo_n = supply_ok & !timed_out;

endmodule

// File: rtl/wdt_edge_watchdog_chk.sv
module wdt_edge_watchdog_chk #(
  parameter int unsigned TIMEOUT_CYCLES = 1600
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic rst_asserted,
  input logic wdo_n,
  input logic edge_evt,
  input logic float_s,
  input logic clear_evt,
  input logic timed_out
);

  localparam int unsigned QW = $clog2(TIMEOUT_CYCLES + 2) + 1;
  localparam logic [QW-1:0] QSAT = {QW{1'b1}};

  logic [QW-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 quiet_cnt <= '0;
    else if (clear_evt)         quiet_cnt <= '0;
    else if (quiet_cnt != QSAT) quiet_cnt <= quiet_cnt + 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_clear_R1: assert (!timed_out);
  end

  assert_timeout_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> quiet_cnt == QW'(TIMEOUT_CYCLES));

  assert_edge_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> !timed_out);

  assert_sysrst_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_asserted |=> !timed_out);

  assert_float_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    float_s |=> !timed_out);

  assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (timed_out && !clear_evt) |=> timed_out);

  assert_low_supply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !wdo_n);

  assert_recovery_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!supply_ok) && supply_ok) |-> wdo_n);

endmodule

bind wdt_edge_watchdog wdt_edge_watchdog_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .supply_ok    (supply_ok),
  .rst_asserted (rst_asserted),
  .wdo_n        (wdo_n),
  .edge_evt     (edge_evt),
  .float_s      (float_s),
  .clear_evt    (clear_evt),
  .timed_out    (timed_out)
);

// File: tb/wdt_edge_watchdog_bench.sv
module wdt_edge_watchdog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst_n, wdi, wdi_float, supply_ok, rst_asserted;
  logic wdo_n;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  int    q_cyc[$];
  logic  q_val[$];
  string q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_edge_watchdog #(.TIMEOUT_CYCLES(T)) u_wdt_edge_watchdog (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdi          (wdi),
    .wdi_float    (wdi_float),
    .supply_ok    (supply_ok),
    .rst_asserted (rst_asserted),
    .wdo_n        (wdo_n)
  );

  // Driver side: queue an expected output value at a cycle offset from now.
  task automatic expect_rel(input int off, input logic v, input string tag);
    q_cyc.push_back(cyc + off);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare queued expectations shortly after each falling edge.
  always @(negedge clk) begin
    #1;
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      checks++;
      if (q_cyc[0] < cyc) begin
        errors++;
        $display("FAIL %s: missed sample at cycle %0d (actual cycle %0d, expected %b)",
                 q_tag[0], q_cyc[0], cyc, q_val[0]);
      end else if (wdo_n !== q_val[0]) begin
        errors++;
        $display("FAIL %s: cycle %0d wdo_n actual=%b expected=%b",
                 q_tag[0], cyc, wdo_n, q_val[0]);
      end
      void'(q_cyc.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  initial begin
    rst_n = 1'b0; wdi = 1'b0; wdi_float = 1'b0; supply_ok = 1'b1; rst_asserted = 1'b0;
    step(3);
    // R1: reset state
    expect_rel(0, 1'b1, "R1 reset state");
    step(1);
    // R2: release counts as a clear; timeout after T cycles
    rst_n = 1'b1;
    expect_rel(T-1, 1'b1, "R2 just before timeout");
    expect_rel(T,   1'b0, "R2 timeout after release");
    expect_rel(T+20, 1'b0, "R6 stays latched low");
    step(T+25);
    // R3: rising edge clears latch at third edge
    wdi = 1'b1;
    expect_rel(2, 1'b0, "R6 low until clear sampled");
    expect_rel(3, 1'b1, "R3 rising edge clears");
    expect_rel(3+T-1, 1'b1, "R2 before timeout after kick");
    expect_rel(3+T, 1'b0, "R2 timeout after kick");
    step(3+T+3);
    // R3: alternating kicks keep it alive
    for (int i = 0; i < 4; i++) begin
      wdi = ~wdi;
      expect_rel(29, 1'b1, "R3 kicks keep alive");
      step(30);
    end
    // R3: last change is a falling edge (wdi is 1 after four toggles from 1? ensure fall)
    wdi = 1'b1;
    step(5);
    wdi = 1'b0;
    expect_rel(3+T-1, 1'b1, "R3 falling edge clears");
    expect_rel(3+T, 1'b0, "R3 timeout after falling edge");
    step(3+T+3);
    // R7: single-period pulse from timed-out state
    wdi = 1'b1;
    expect_rel(2, 1'b0, "R7 before pulse seen");
    expect_rel(3, 1'b1, "R7 short pulse is activity");
    step(1);
    wdi = 1'b0;
    expect_rel(3+T-1, 1'b1, "R7 second change restarts count");
    expect_rel(3+T, 1'b0, "R7 timeout after pulse");
    step(3+T+3);
    // R4: reset-asserted holds the timer cleared
    rst_asserted = 1'b1;
    expect_rel(0, 1'b0, "R4 before sampled");
    expect_rel(1, 1'b1, "R4 reset asserted clears");
    expect_rel(50, 1'b1, "R4 held cleared past timeout");
    expect_rel(60+T-1, 1'b1, "R4 before timeout after release");
    expect_rel(60+T, 1'b0, "R4 timeout after release");
    step(60);
    rst_asserted = 1'b0;
    step(T+3);
    // R5: floating input disables the watchdog
    wdi_float = 1'b1;
    expect_rel(2, 1'b0, "R5 float not yet synchronised");
    expect_rel(3, 1'b1, "R5 float clears");
    expect_rel(70, 1'b1, "R5 disabled while floating");
    expect_rel(80+2+T-1, 1'b1, "R5 before timeout after float ends");
    expect_rel(80+2+T, 1'b0, "R5 timeout after float ends");
    step(80);
    wdi_float = 1'b0;
    step(2+T+3);
    // R8/R9: supply dip mid-count
    wdi = 1'b1;
    step(10);
    supply_ok = 1'b0;
    expect_rel(0, 1'b0, "R8 low supply forces low at once");
    expect_rel(3, 1'b0, "R8 low supply holds low");
    step(5);
    supply_ok = 1'b1;
    expect_rel(0, 1'b1, "R9 immediate return high");
    expect_rel(T-1, 1'b1, "R8 timer cleared during low supply");
    expect_rel(T, 1'b0, "R8 timeout counted from recovery");
    step(T+3);
    wait (q_cyc.size() == 0);
    step(1);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule